// File: doc/BRIEF.md
# Configurable Interrupt Request Capture

This block gathers the external interrupt requests of a 16-bit processor core and turns them into a pending-request vector the core can read and clear. It accepts one power-down request, six user request lines and two active-high I/O-level expansion lines. Every line is brought into the CPU clock domain through a synchronizer before it is examined.

A single configuration bit decides how the power-down and user lines are sensed. In edge mode a rising edge sets a sticky pending bit that the core clears bit by bit. In level mode the pending bit simply tracks the synchronized line. The two expansion lines are always level sensed. A mask and a global enable gate every request except power-down, which always reaches the request output. All pins are plain control and status signals; no stream handshake is involved, so there is no back-pressure.

Pending vector layout: bit 0 is power-down, bits 1 to 6 are user lines 0 to 5, bits 7 and 8 are expansion lines 1 and 2. Mask bit k (0 to 7) covers pending bit k+1. A mask bit of 1 blocks that request.

Top module: `irq_capture`

## Requirements
- R1: While `rst_n` is low, and after it rises, `pend_o` is all zero, `irq_o` is low, the mask is all zero and the global enable is off.
- R2: A change on any request input shows on `pend_o` (in level sensing) after the third rising clock edge following the change, not earlier.
- R3: With `level_mode_i` = 0, a rising edge on the synchronized power-down or user line sets its pending bit, which then stays set after the line falls until cleared.
- R4: With `level_mode_i` = 0, a 1 on `clr_i[k]` at a clock edge clears pending bit k, unless a new rising edge for that bit arrives on the same edge, in which case the bit stays set.
- R5: With `level_mode_i` = 1, the power-down and user pending bits equal their synchronized inputs, and `clr_i` has no effect on them.
- R6: The expansion pending bits 7 and 8 always equal their synchronized inputs, whatever `level_mode_i` and `clr_i` hold.
- R7: A pending bit whose mask bit is 1 still shows on `pend_o` but does not raise `irq_o`.
- R8: With the global enable off, no pending bit except bit 0 can raise `irq_o`; `en_wr_i` loads the enable from `en_data_i`, and `mask_wr_i` loads the mask from `mask_data_i`, both on the clock edge.
- R9: Pending bit 0 (power-down) raises `irq_o` regardless of the mask and the global enable.
- R10: In edge mode, a line held high after its pending bit is cleared does not set the bit again until it falls and rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_dn_i | input | 1 | Power-down request, asynchronous |
| usr_irq_i | input | 6 | User request lines 0 to 5, asynchronous |
| iol_irq_i | input | 2 | Expansion request lines 1 and 2, active high |
| level_mode_i | input | 1 | 1 = level sensing, 0 = rising-edge sensing for power-down and user lines |
| mask_wr_i | input | 1 | Load the mask from `mask_data_i` |
| mask_data_i | input | 8 | New mask, bit k blocks pending bit k+1 |
| en_wr_i | input | 1 | Load the global enable from `en_data_i` |
| en_data_i | input | 1 | New global enable value |
| clr_i | input | 9 | Per-bit clear of edge-mode pending bits |
| pend_o | output | 9 | Pending-request vector |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The hardest case to reach from the ports is a clear that lands on the very edge where a fresh rising edge reaches the pending latch, since the synchronizer hides the exact cycle from the stimulus side. The bench reaches it by pulsing lines and asserting clears on every cycle of a stretch, and by a long random phase that toggles lines, clears, mask, enable and the sense mode each cycle, with a cycle-exact model deciding which of set or clear wins. Switching the sense mode while lines are high and pending bits are set is also driven, so stale latched bits and re-arming of held lines are compared every clock.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= async_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_latch.sv
module irq_latch
  import irq_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] level_sel_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    sense_e mode;
    logic   rise;
    assign mode = sense_e'(level_sel_i[b]);
    assign rise = sync_i[b] & ~prev_q[b];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b] <= 1'b0;
      end else if (mode == SENSE_LEVEL) begin
        pend_q[b] <= sync_i[b];
      end else begin
        pend_q[b] <= rise | (pend_q[b] & ~clr_i[b]);
      end
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int MASK_W = 8
) (
  input  logic              pwr_pend_i,
  input  logic [MASK_W-1:0] req_pend_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              enable_i,
  output logic              irq_o
);
  logic any_open;
  assign any_open = |(req_pend_i & ~mask_i);
  assign irq_o    = pwr_pend_i | (enable_i & any_open);
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int USR_N       = 6,
  parameter int IOL_N       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pwr_dn_i,
  input  logic [USR_N-1:0]       usr_irq_i,
  input  logic [IOL_N-1:0]       iol_irq_i,
  input  logic                   level_mode_i,
  input  logic                   mask_wr_i,
  input  logic [USR_N+IOL_N-1:0] mask_data_i,
  input  logic                   en_wr_i,
  input  logic                   en_data_i,
  input  logic [USR_N+IOL_N:0]   clr_i,
  output logic [USR_N+IOL_N:0]   pend_o,
  output logic                   irq_o
);
  localparam int MASK_W = USR_N + IOL_N;
  localparam int TOTAL  = MASK_W + 1;

  logic [TOTAL-1:0]  raw;
  logic [TOTAL-1:0]  sync_q;
  logic [TOTAL-1:0]  level_sel;
  logic [MASK_W-1:0] mask_q;
  logic              en_q;

  assign raw       = {iol_irq_i, usr_irq_i, pwr_dn_i};
  assign level_sel = {{IOL_N{1'b1}}, {(USR_N+1){level_mode_i}}};

  irq_sync #(.WIDTH(TOTAL), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (raw),
    .sync_o  (sync_q)
  );

  irq_latch #(.WIDTH(TOTAL)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_q),
    .level_sel_i (level_sel),
    .clr_i       (clr_i),
    .pend_o      (pend_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_wr_i) mask_q <= mask_data_i;
      if (en_wr_i)   en_q   <= en_data_i;
    end
  end

  irq_gate #(.MASK_W(MASK_W)) u_gate (
    .pwr_pend_i (pend_o[0]),
    .req_pend_i (pend_o[TOTAL-1:1]),
    .mask_i     (mask_q),
    .enable_i   (en_q),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/irq_capture_chk.sv
module irq_capture_chk #(
  parameter int USR_N = 6,
  parameter int IOL_N = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 level_mode_i,
  input logic [USR_N+IOL_N:0] clr_i,
  input logic [USR_N+IOL_N:0] pend_o,
  input logic [USR_N+IOL_N:0] sync_q,
  input logic                 en_q,
  input logic                 irq_o
);
  localparam int TOTAL = USR_N + IOL_N + 1;

  AST_PWR_ALWAYS_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    pend_o[0] |-> irq_o); // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !pend_o[0]) |-> !irq_o); // R8

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !level_mode_i |=> ((pend_o[USR_N:0] & $past(pend_o[USR_N:0] & ~clr_i[USR_N:0]))
                       == $past(pend_o[USR_N:0] & ~clr_i[USR_N:0]))); // R3

  AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode_i |=> (pend_o[USR_N:0] == $past(sync_q[USR_N:0]))); // R5

  AST_IOL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend_o[TOTAL-1:USR_N+1] == $past(sync_q[TOTAL-1:USR_N+1]))); // R6
endmodule

bind irq_capture irq_capture_chk #(.USR_N(USR_N), .IOL_N(IOL_N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .level_mode_i (level_mode_i),
  .clr_i        (clr_i),
  .pend_o       (pend_o),
  .sync_q       (sync_q),
  .en_q         (en_q),
  .irq_o        (irq_o)
);

// File: tb/tb_irq_capture.sv
module tb_irq_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_dn_i = 1'b0;
  logic [5:0] usr_irq_i = '0;
  logic [1:0] iol_irq_i = '0;
  logic       level_mode_i = 1'b0;
  logic       mask_wr_i = 1'b0;
  logic [7:0] mask_data_i = '0;
  logic       en_wr_i = 1'b0;
  logic       en_data_i = 1'b0;
  logic [8:0] clr_i = '0;
  logic [8:0] pend_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string req = "R1";

  // reference model state
  logic [8:0] m_d1 = '0, m_d2 = '0, m_prv = '0, m_pend = '0;
  logic [7:0] m_mask = '0;
  logic       m_en = 1'b0;

  always #5 clk = ~clk;

  irq_capture dut (
    .clk(clk), .rst_n(rst_n), .pwr_dn_i(pwr_dn_i), .usr_irq_i(usr_irq_i),
    .iol_irq_i(iol_irq_i), .level_mode_i(level_mode_i), .mask_wr_i(mask_wr_i),
    .mask_data_i(mask_data_i), .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .clr_i(clr_i), .pend_o(pend_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    logic [8:0] nxt;
    if (!rst_n) begin
      m_d1 = '0; m_d2 = '0; m_prv = '0; m_pend = '0; m_mask = '0; m_en = 1'b0;
    end else begin
      for (int b = 0; b < 9; b++) begin
        if (b >= 7 || level_mode_i) nxt[b] = m_d2[b];
        else nxt[b] = (m_d2[b] && !m_prv[b]) || (m_pend[b] && !clr_i[b]);
      end
      m_prv = m_d2; m_d2 = m_d1; m_d1 = {iol_irq_i, usr_irq_i, pwr_dn_i};
      m_pend = nxt;
      if (mask_wr_i) m_mask = mask_data_i;
      if (en_wr_i)   m_en = en_data_i;
    end
  end

  function automatic logic exp_irq();
    return m_pend[0] || (m_en && ((m_pend[8:1] & ~m_mask) != 0));
  endfunction

  task automatic check(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check({req, " pend_o"}, pend_o, m_pend);
    check({req, " irq_o"}, {8'b0, irq_o}, {8'b0, exp_irq()});
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic set_en(logic v);
    en_wr_i = 1'b1; en_data_i = v; tick(); en_wr_i = 1'b0;
  endtask

  task automatic set_mask(logic [7:0] v);
    mask_wr_i = 1'b1; mask_data_i = v; tick(); mask_wr_i = 1'b0;
  endtask

  initial begin
    // R1: reset state
    req = "R1";
    ticks(3);
    check("R1 pend zero in reset", pend_o, 9'h000);
    rst_n = 1'b1;
    tick();
    check("R1 pend zero after reset", pend_o, 9'h000);
    check("R1 irq low after reset", {8'b0, irq_o}, 9'h000);
    // R1: enable off after reset: a level expansion request shows but no irq
    iol_irq_i = 2'b01;
    ticks(4);
    check("R1 enable off", {8'b0, irq_o}, 9'h000);
    iol_irq_i = 2'b00;
    ticks(4);

    // R2: latency of exactly three edges in level mode
    req = "R2";
    level_mode_i = 1'b1;
    ticks(2);
    usr_irq_i = 6'b000001;
    tick(); check("R2 not after 1", pend_o, 9'h000);
    tick(); check("R2 not after 2", pend_o, 9'h000);
    tick(); check("R2 seen after 3", pend_o, 9'h002);
    usr_irq_i = '0;
    ticks(4);

    // R3: edge mode sticky bit
    req = "R3";
    level_mode_i = 1'b0;
    set_en(1'b1);
    usr_irq_i = 6'b000100;
    tick(); usr_irq_i = '0;
    ticks(6);
    check("R3 sticky after fall", pend_o, 9'h008);
    check("R3 irq raised", {8'b0, irq_o}, 9'h001);

    // R4: clear
    req = "R4";
    clr_i = 9'h008; tick(); clr_i = '0;
    check("R4 cleared", pend_o, 9'h000);
    // clears asserted every cycle while lines pulse: set vs clear race
    for (int i = 0; i < 12; i++) begin
      usr_irq_i = (i % 3 == 0) ? 6'b111111 : 6'b000000;
      pwr_dn_i  = (i % 2 == 0);
      clr_i = 9'h1FF;
      tick();
    end
    clr_i = '0; usr_irq_i = '0; pwr_dn_i = 1'b0;
    ticks(5);
    clr_i = 9'h1FF; tick(); clr_i = '0;

    // R10: held line does not retrigger after clear
    req = "R10";
    usr_irq_i = 6'b001000;
    ticks(5);
    clr_i = 9'h010; tick(); clr_i = '0;
    ticks(6);
    check("R10 no retrigger while held", pend_o, 9'h000);
    usr_irq_i = '0; ticks(3); usr_irq_i = 6'b001000; ticks(4);
    check("R10 retrigger after new rise", pend_o, 9'h010);
    usr_irq_i = '0; clr_i = 9'h1FF; tick(); clr_i = '0;

    // R5: level mode follows, clear ignored
    req = "R5";
    level_mode_i = 1'b1;
    usr_irq_i = 6'b100010; pwr_dn_i = 1'b0;
    ticks(4);
    clr_i = 9'h1FF; ticks(2); clr_i = '0;
    check("R5 clear ignored", pend_o, 9'h044);
    usr_irq_i = '0; ticks(4);
    check("R5 follows low", pend_o, 9'h000);

    // R6: expansion lines level sensed in edge mode
    req = "R6";
    level_mode_i = 1'b0;
    iol_irq_i = 2'b10; ticks(4);
    clr_i = 9'h180; tick(); clr_i = '0;
    check("R6 iol held", pend_o, 9'h100);
    iol_irq_i = 2'b00; ticks(4);
    check("R6 iol dropped", pend_o, 9'h000);

    // R7: mask blocks irq, pending still shown
    req = "R7";
    set_mask(8'h80);
    iol_irq_i = 2'b10; ticks(4);
    check("R7 masked pending visible", pend_o, 9'h100);
    check("R7 masked no irq", {8'b0, irq_o}, 9'h000);
    set_mask(8'h00); tick();
    check("R7 unmask raises", {8'b0, irq_o}, 9'h001);

    // R8: global enable off blocks
    req = "R8";
    set_en(1'b0); tick();
    check("R8 disabled no irq", {8'b0, irq_o}, 9'h000);
    iol_irq_i = 2'b00; ticks(4);

    // R9: power-down ignores mask and enable
    req = "R9";
    set_mask(8'hFF);
    pwr_dn_i = 1'b1; tick(); pwr_dn_i = 1'b0;
    ticks(5);
    check("R9 pwr irq", {8'b0, irq_o}, 9'h001);
    clr_i = 9'h001; tick(); clr_i = '0;

    // random phase covering all requirements together (R3 R4 R5 R7 R8)
    req = "R4";
    for (int i = 0; i < 3000; i++) begin
      pwr_dn_i     = ($urandom % 8) == 0;
      usr_irq_i    = 6'($urandom);
      iol_irq_i    = 2'($urandom);
      clr_i        = 9'($urandom) & 9'($urandom);
      level_mode_i = ($urandom % 16) == 0 ? ~level_mode_i : level_mode_i;
      mask_wr_i    = ($urandom % 10) == 0;
      mask_data_i  = 8'($urandom);
      en_wr_i      = ($urandom % 10) == 0;
      en_data_i    = 1'($urandom);
      tick();
    end
    mask_wr_i = 1'b0; en_wr_i = 1'b0;

    // R1: reset mid-run clears everything
    req = "R1";
    rst_n = 1'b0; tick();
    check("R1 mid-run reset", pend_o, 9'h000);
    rst_n = 1'b1; tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule